// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This controller sits on the host side of a parallel NOR flash and erases one block each time it is asked. A single-cycle start request carries the block address. The controller then drives the device bus itself. It writes the erase setup command and the erase confirm command to that block. It reads the status byte repeatedly until the device reports ready. It can optionally classify the outcome and clear the status if something went wrong. Finally it puts the device back into array-read mode. When the work is finished it raises a one-cycle done pulse together with a result code.

Per-erase checking can be turned off with a configuration input. In that mode a long series of erases is not slowed by the status decode, and the caller can inspect the status once at the end of the series. A programmable poll limit protects the caller from a device that never becomes ready.

Top module: `flash_erase_seq`

## Requirements
- R1: During and right after reset, busy and donePulse are low and the chip enable, output enable and write enable strobes (all active low) are high.
- R2: A start request accepted while idle produces a bus write of data 0x20 to the latched block address, followed by a bus write of data 0xD0 to the same address.
- R3: In every bus write, the write enable is low for exactly WE_LOW_CYC clock cycles. Chip enable is low and the data driver is on whenever write enable is low. Address and data do not change while write enable is low.
- R4: After the confirm write the block reads the status byte. Chip enable and output enable go low for each read, and output enable returns high for at least one cycle between reads. Reading continues while status bit 7 is 0 and stops at the first read where bit 7 is 1.
- R5: With per-erase checking on, the ready status is classified by priority into the result code. Bit 3 set gives 1 (supply range). Otherwise bits 4 and 5 both set give 2 (command sequence). Otherwise bit 5 set gives 3 (erase failure). Otherwise bit 1 set gives 4 (locked block). Anything else gives 0 (success).
- R6: When per-erase checking finds a non-zero code, a write of data 0x50 to the block address comes before the final write. It does not occur when the code is 0.
- R7: Every operation ends with a write of data 0xFF to the block address, and only after that does donePulse rise.
- R8: With per-erase checking off (fullCheck = 0), the error bits are not decoded, no 0x50 write is made, and the result code is 0.
- R9: If pollLimit reads complete without bit 7 set, the block stops polling, makes no 0x50 write, writes 0xFF and reports result code 5.
- R10: donePulse lasts exactly one cycle, and busy is low in that cycle. A start request that arrives while busy is ignored: no extra bus operation and no extra done pulse, and the address used stays the one latched first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request to erase blockAddr |
| blockAddr | input | ADDR_W | Address of the block to erase |
| fullCheck | input | 1 | 1 = decode status after this erase, 0 = deferred check |
| pollLimit | input | POLL_W | Maximum number of status reads |
| busy | output | 1 | Operation in progress |
| donePulse | output | 1 | One-cycle completion strobe |
| resultCode | output | 3 | Outcome code, valid with donePulse |
| flAddr | output | ADDR_W | Flash address bus |
| flDout | output | DATA_W | Flash write data |
| flDoe | output | 1 | Data driver enable for flDout |
| flDin | input | 8 | Low byte of flash read data (status) |
| flCeN | output | 1 | Chip enable, active low |
| flOeN | output | 1 | Output enable, active low |
| flWeN | output | 1 | Write enable, active low |

## Verification
The erase is run against a device model whose status byte holds each error bit combination in turn. These include several bits set together, which shows whether the priority order is respected, and bit 4 alone, which must read as success. Ready latency is varied between zero and several busy reads, which separates a correct poll loop from one that stops early or reads once too often. A latency beyond the poll limit produces the timeout path. The same error pattern is also run with deferred checking, which shows that the decode and the clear write depend on the mode. A second start in the middle of an erase shows whether the block latches a new request while busy.

// File: rtl/fes_pkg.sv
package fes_pkg;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_VPP     = 3'd1,
    RES_SEQ     = 3'd2,
    RES_ERASE   = 3'd3,
    RES_LOCKED  = 3'd4,
    RES_TIMEOUT = 3'd5
  } fes_result_e;

  typedef struct packed {
    logic       loadAddr;
    logic       startWr;
    logic       startRd;
    logic       clrPoll;
    logic [7:0] cmd;
  } fes_strobe_t;

  function automatic fes_result_e decodeStatus(input logic [7:0] sr);
    if (sr[3])               return RES_VPP;
    else if (sr[4] && sr[5]) return RES_SEQ;
    else if (sr[5])          return RES_ERASE;
    else if (sr[1])          return RES_LOCKED;
    else                     return RES_OK;
  endfunction

endpackage

// File: rtl/fes_datapath.sv
module fes_datapath
  import fes_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int WE_LOW_CYC = 3,
  parameter int READ_CYC   = 2,
  parameter int POLL_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fes_strobe_t       strobe,
  input  logic [ADDR_W-1:0] blockAddr,
  input  logic [POLL_W-1:0] pollLimit,
  input  logic [7:0]        flDin,
  output logic              opDone,
  output logic [7:0]        statusByte,
  output logic              pollExhausted,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flDout,
  output logic              flDoe,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN
);

  localparam int MAX_CYC = (WE_LOW_CYC > READ_CYC) ? WE_LOW_CYC : READ_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    B_IDLE, B_SETUP, B_WLOW, B_HOLD, B_GAP, B_READ, B_RGAP
  } bus_phase_e;

  bus_phase_e        phase;
  logic [CNT_W-1:0]  phaseCnt;
  logic [7:0]        cmdReg;
  logic [ADDR_W-1:0] addrReg;
  logic [POLL_W-1:0] pollCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= B_IDLE;
      phaseCnt   <= '0;
      cmdReg     <= '0;
      addrReg    <= '0;
      pollCnt    <= '0;
      statusByte <= '0;
    end else begin
      if (strobe.loadAddr) addrReg <= blockAddr;
      if (strobe.clrPoll)  pollCnt <= '0;
      case (phase)
        B_IDLE: begin
          phaseCnt <= '0;
          if (strobe.startWr) begin
            phase  <= B_SETUP;
            cmdReg <= strobe.cmd;
          end else if (strobe.startRd) begin
            phase   <= B_READ;
            pollCnt <= pollCnt + 1'b1;
          end
        end
        B_SETUP: phase <= B_WLOW;
        B_WLOW: begin
          if (phaseCnt == CNT_W'(WE_LOW_CYC - 1)) begin
            phase    <= B_HOLD;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        B_HOLD: phase <= B_GAP;
        B_GAP:  phase <= B_IDLE;
        B_READ: begin
          if (phaseCnt == CNT_W'(READ_CYC - 1)) begin
            statusByte <= flDin;
            phase      <= B_RGAP;
            phaseCnt   <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        B_RGAP:  phase <= B_IDLE;
        default: phase <= B_IDLE;
      endcase
    end
  end

  always_comb begin
    opDone        = (phase == B_GAP) || (phase == B_RGAP);
    pollExhausted = (pollCnt >= pollLimit);
    flDoe         = (phase == B_SETUP) || (phase == B_WLOW) || (phase == B_HOLD);
    flCeN         = !(flDoe || (phase == B_READ));
    flWeN         = (phase != B_WLOW);
    flOeN         = (phase != B_READ);
    flAddr        = addrReg;
    flDout        = flDoe ? {{(DATA_W-8){1'b0}}, cmdReg} : '0;
  end

  // R3
  we_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flWeN |-> (!flCeN && flDoe));

  // R3
  we_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flWeN && $past(!flWeN)) |-> ($stable(flDout) && $stable(flAddr)));

  // R4
  oe_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flOeN) |=> flOeN);

  // R4
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flOeN |-> flWeN);

endmodule

// File: rtl/fes_ctrl.sv
module fes_ctrl
  import fes_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        fullCheck,
  input  logic        opDone,
  input  logic [7:0]  statusByte,
  input  logic        pollExhausted,
  output fes_strobe_t strobe,
  output logic        busy,
  output logic        donePulse,
  output logic [2:0]  resultCode
);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_CONFIRM, S_POLL, S_CLEAR, S_ARRAY
  } ctrl_state_e;

  ctrl_state_e state;
  logic        pending;
  logic        fullChkReg;
  fes_result_e resReg;
  fes_result_e decoded;

  assign decoded = decodeStatus(statusByte);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      pending    <= 1'b0;
      fullChkReg <= 1'b0;
      resReg     <= RES_OK;
      donePulse  <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      if (pending) pending <= 1'b0;
      case (state)
        S_IDLE: if (startReq) begin
          state      <= S_SETUP;
          pending    <= 1'b1;
          fullChkReg <= fullCheck;
          resReg     <= RES_OK;
        end
        S_SETUP: if (opDone) begin
          state   <= S_CONFIRM;
          pending <= 1'b1;
        end
        S_CONFIRM: if (opDone) begin
          state   <= S_POLL;
          pending <= 1'b1;
        end
        S_POLL: if (opDone) begin
          pending <= 1'b1;
          if (statusByte[7]) begin
            if (fullChkReg && (decoded != RES_OK)) begin
              resReg <= decoded;
              state  <= S_CLEAR;
            end else begin
              resReg <= RES_OK;
              state  <= S_ARRAY;
            end
          end else if (pollExhausted) begin
            resReg <= RES_TIMEOUT;
            state  <= S_ARRAY;
          end
        end
        S_CLEAR: if (opDone) begin
          state   <= S_ARRAY;
          pending <= 1'b1;
        end
        S_ARRAY: if (opDone) begin
          state     <= S_IDLE;
          donePulse <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.loadAddr = (state == S_IDLE) && startReq;
    strobe.startRd  = pending && (state == S_POLL);
    strobe.startWr  = pending && (state != S_POLL) && (state != S_IDLE);
    strobe.clrPoll  = (state == S_CONFIRM) && opDone;
    case (state)
      S_SETUP:   strobe.cmd = CMD_ERASE_SETUP;
      S_CONFIRM: strobe.cmd = CMD_ERASE_GO;
      S_CLEAR:   strobe.cmd = CMD_CLR_STATUS;
      S_ARRAY:   strobe.cmd = CMD_READ_ARRAY;
      default:   strobe.cmd = 8'h00;
    endcase
    busy       = (state != S_IDLE);
    resultCode = resReg;
  end

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !busy);

  // R5
  code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (resultCode <= 3'd5));

  // R8
  deferred_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && !fullChkReg) |-> (resultCode == 3'd0 || resultCode == 3'd5));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int WE_LOW_CYC = 3,
  parameter int READ_CYC   = 2,
  parameter int POLL_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] blockAddr,
  input  logic              fullCheck,
  input  logic [POLL_W-1:0] pollLimit,
  output logic              busy,
  output logic              donePulse,
  output logic [2:0]        resultCode,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flDout,
  output logic              flDoe,
  input  logic [7:0]        flDin,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN
);

  fes_strobe_t strobe;
  logic        opDone;
  logic [7:0]  statusByte;
  logic        pollExhausted;

  fes_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .startReq      (startReq),
    .fullCheck     (fullCheck),
    .opDone        (opDone),
    .statusByte    (statusByte),
    .pollExhausted (pollExhausted),
    .strobe        (strobe),
    .busy          (busy),
    .donePulse     (donePulse),
    .resultCode    (resultCode)
  );

  fes_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .WE_LOW_CYC (WE_LOW_CYC),
    .READ_CYC   (READ_CYC),
    .POLL_W     (POLL_W)
  ) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .blockAddr     (blockAddr),
    .pollLimit     (pollLimit),
    .flDin         (flDin),
    .opDone        (opDone),
    .statusByte    (statusByte),
    .pollExhausted (pollExhausted),
    .flAddr        (flAddr),
    .flDout        (flDout),
    .flDoe         (flDoe),
    .flCeN         (flCeN),
    .flOeN         (flOeN),
    .flWeN         (flWeN)
  );

endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int WE_LOW = 3;
  localparam int POLL_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic [ADDR_W-1:0] blockAddr = '0;
  logic              fullCheck = 1'b1;
  logic [POLL_W-1:0] pollLimit = 16'd20;
  logic              busy, donePulse, flDoe, flCeN, flOeN, flWeN;
  logic [2:0]        resultCode;
  logic [ADDR_W-1:0] flAddr;
  logic [DATA_W-1:0] flDout;
  logic [7:0]        flDin;

  always #2.5 clk = ~clk;

  flash_erase_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WE_LOW_CYC(WE_LOW),
                    .READ_CYC(2), .POLL_W(POLL_W)) u_flash_erase_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .blockAddr(blockAddr),
    .fullCheck(fullCheck), .pollLimit(pollLimit), .busy(busy),
    .donePulse(donePulse), .resultCode(resultCode), .flAddr(flAddr),
    .flDout(flDout), .flDoe(flDoe), .flDin(flDin), .flCeN(flCeN),
    .flOeN(flOeN), .flWeN(flWeN)
  );

  int checks = 0;
  int errors = 0;

  // device model: busy for mBusy reads after the confirm write, then mStatus
  int         mBusy = 0;
  logic [7:0] mStatus = 8'h80;
  int         mReads = 0;
  assign flDin = (mReads >= mBusy) ? mStatus : 8'h00;

  // scoreboard queues
  logic [ADDR_W+7:0] expWr[$];
  logic [2:0]        expRes[$];
  int                expReads[$];
  int                doneCnt = 0;

  logic prevWe = 1'b1, prevOe = 1'b1, prevDone = 1'b0;
  int   weLow = 0;
  int   readsThis = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (!flWeN) weLow++;
      if (!prevWe && flWeN) begin
        chk(weLow == WE_LOW, "R3 we low width", weLow, WE_LOW);
        if (expWr.size() == 0) chk(0, "R2/R7 unexpected write", int'(flDout[7:0]), 0);
        else begin
          logic [ADDR_W+7:0] e;
          e = expWr.pop_front();
          chk({flAddr, flDout[7:0]} == e, "R2/R6/R7 write addr+data",
              int'({flAddr, flDout[7:0]}), int'(e));
        end
        if (flDout[7:0] == 8'hD0) mReads = 0;
        weLow = 0;
      end
      if (!prevOe && flOeN) begin
        mReads++;
        readsThis++;
      end
      chk(!(prevDone && donePulse), "R10 done one cycle", int'(donePulse), 0);
      if (donePulse) begin
        chk(!busy, "R10 busy low at done", int'(busy), 0);
        chk(expWr.size() == 0, "R7 all writes before done", expWr.size(), 0);
        if (expRes.size() == 0) chk(0, "R10 unexpected done", 1, 0);
        else begin
          logic [2:0] r;
          int n;
          r = expRes.pop_front();
          n = expReads.pop_front();
          chk(resultCode == r, "R5/R8/R9 result code", int'(resultCode), int'(r));
          chk(readsThis == n, "R4/R9 status read count", readsThis, n);
        end
        readsThis = 0;
        doneCnt++;
      end
      prevWe = flWeN;
      prevOe = flOeN;
      prevDone = donePulse;
    end
  end

  function automatic logic [2:0] refCode(input logic [7:0] s);
    if (s[3])              return 3'd1;
    else if (s[4] && s[5]) return 3'd2;
    else if (s[5])         return 3'd3;
    else if (s[1])         return 3'd4;
    else                   return 3'd0;
  endfunction

  task automatic runErase(input logic [ADDR_W-1:0] a, input bit fc,
                          input int busyN, input logic [7:0] st,
                          input int lim, input bit poke);
    logic [2:0] code;
    int reads;
    int target;
    if (busyN >= lim) begin
      code = 3'd5;
      reads = lim;
    end else begin
      reads = busyN + 1;
      code = fc ? refCode(st) : 3'd0;
    end
    expWr.push_back({a, 8'h20});
    expWr.push_back({a, 8'hD0});
    if (code >= 3'd1 && code <= 3'd4) expWr.push_back({a, 8'h50});
    expWr.push_back({a, 8'hFF});
    expRes.push_back(code);
    expReads.push_back(reads);
    target = doneCnt + 1;
    mBusy = busyN;
    mStatus = st;
    @(negedge clk);
    blockAddr = a;
    fullCheck = fc;
    pollLimit = POLL_W'(lim);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      chk(busy, "R10 busy mid-operation", int'(busy), 1);
      blockAddr = ~a;
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    while (doneCnt < target) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(doneCnt == target, "R10 single done per start", doneCnt, target);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !donePulse, "R1 busy/done in reset", int'({busy, donePulse}), 0);
    chk(flCeN && flOeN && flWeN, "R1 strobes high in reset",
        int'({flCeN, flOeN, flWeN}), 7);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && flCeN && flOeN && flWeN, "R1 idle after reset",
        int'({busy, flCeN, flOeN, flWeN}), 7);

    runErase(20'h12000, 1'b1, 3, 8'h80, 20, 1'b0); // R2 R4 R7 success
    runErase(20'h34000, 1'b1, 1, 8'hBA, 20, 1'b0); // R5 R6 vpp wins
    runErase(20'h40000, 1'b1, 2, 8'hB2, 20, 1'b0); // R5 seq beats erase/lock
    runErase(20'h51000, 1'b1, 0, 8'hA2, 20, 1'b0); // R5 erase beats lock
    runErase(20'h62000, 1'b1, 4, 8'h82, 20, 1'b0); // R5 locked
    runErase(20'h73000, 1'b1, 1, 8'h90, 20, 1'b0); // R5 bit4 alone is ok
    runErase(20'h84000, 1'b0, 2, 8'hBA, 20, 1'b0); // R8 deferred
    runErase(20'h95000, 1'b1, 10, 8'hA0, 4, 1'b0); // R9 timeout
    runErase(20'hA6000, 1'b1, 3, 8'h80, 4, 1'b0);  // R9 ready on last read
    runErase(20'hB7000, 1'b1, 5, 8'hA0, 20, 1'b1); // R10 start while busy

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule